// File: doc/BRIEF.md
# ID-Filtered Command Decoder with Latched Select Output

This block sits behind a shared bit-level serial core on a software-addressed two-wire slave. After each START it takes the first received byte as a control byte: a fixed four-bit code, one output-enable bit and three command bits. It then takes the second byte as the device identity byte. From these it decides, byte by byte, whether the device should acknowledge. The decision depends on the command, on whether the device already holds an assigned identity, on whether the identity byte matches the stored one, and on whether an internal write cycle is running. Once the identity byte is accepted, it issues the chosen command to the rest of the device.

The block also drives an active-low open-drain select pin, shown here as a "pull low" request. An accepted command sets the pin from the output-enable bit at one defined SCL rising edge, and the pin then holds its state across later frames. When a frame ends by STOP or by a repeated START before the command has all the bytes it needs, the block raises a one-cycle abort pulse. The memory array, the identity register and serial-number arbitration sit outside this block.

Top module: `idcmd_decoder`

## Requirements
- R1: A control byte (first byte after START) whose upper nibble is not 0110, or whose low three bits are not one of 000, 001, 010, 100, 110, gets ack_ok=0. The rest of that frame is ignored: no acknowledge, no cmd_go, no change to sel_pull.
- R2: An accepted control byte gives ack_ok=1 in the cycle after byte_stb. cmd_sel then shows its low three bits: 000 set protection, 001 read, 010 write, 100 assign identity, 110 clear identity. Bit 3 is the output-enable bit.
- R3: When id_assigned=1, an assign-identity control byte (0110x100) gets ack_ok=0.
- R4: For read, write and set-protection, the identity byte is acknowledged and cmd_go pulses for one cycle only when it equals dev_id. On a mismatch that byte and every later byte in the frame get ack_ok=0.
- R5: After an accepted identity byte, write and set-protection bytes get ack_ok=1. Read and assign bytes, which the device sends, get ack_ok=0.
- R6: For assign (when unassigned) and for clear, the identity byte is acknowledged and cmd_go pulses whatever its value.
- R7: A byte strobed while wr_busy=1 gets ack_ok=0. During a write or set-protection frame this also drops the frame, so later bytes get no acknowledge.
- R8: After reset sel_pull=0, ack_ok=0, cmd_go=0, cmd_abort=0 and cmd_sel=000.
- R9: After an accepted identity byte, sel_pull takes the output-enable bit on the first scl_rise that follows the ack_rise of that byte, and not earlier. When STOP follows straight after, this is the rising edge just before STOP.
- R10: sel_pull holds its value across frames that never reach an accepted identity byte.
- R11: cmd_abort pulses in the cycle after a START or STOP that ends a live frame holding fewer bytes than its command needs (read 2, clear 2, write 4, set protection 4, assign 2 plus the serial length). It stays 0 otherwise.
- R12: A START or STOP that arrives between the identity byte and the committing scl_rise cancels the pending change to sel_pull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_evt | input | 1 | START or repeated START seen (one-cycle strobe) |
| stop_evt | input | 1 | STOP seen (one-cycle strobe) |
| scl_rise | input | 1 | Rising SCL edge seen (one-cycle strobe) |
| ack_rise | input | 1 | Rising SCL edge within the acknowledge slot (strobe) |
| byte_stb | input | 1 | A complete byte is on rx_byte (strobe) |
| rx_byte | input | 8 | Byte assembled by the bit-level core |
| dev_id | input | 8 | Stored device identity |
| id_assigned | input | 1 | Identity has been assigned |
| wr_busy | input | 1 | Internal write cycle in progress |
| ack_ok | output | 1 | Acknowledge the most recent byte |
| cmd_sel | output | 3 | Command bits of the last accepted control byte |
| cmd_go | output | 1 | One-cycle pulse: command accepted past the identity byte |
| cmd_abort | output | 1 | One-cycle pulse: live frame ended early |
| sel_pull | output | 1 | 1 = pull the select pin low; 0 = release it |

## Verification
The bench uses the default parameters: control code 0110, a six-byte serial field (so a full assign frame is eight bytes) and a four-byte minimum write frame. With these, both a complete assign frame and a truncated one fit in a short directed run, and so do write frames cut off after the address byte. It also drives identity values 00h, 37h, 05h and FFh, so it covers matching and mismatching identity bytes in both the default and the assigned state. It samples the select output between the acknowledge edge and the committing edge, and again after a repeated START, to show where the pin changes and where it must not.

// File: rtl/idcmd_pkg.sv
// Shared command encoding for the identity-filtered command decoder.
package idcmd_pkg;
    typedef enum logic [2:0] {
        CMD_PROT   = 3'b000,
        CMD_READ   = 3'b001,
        CMD_WRITE  = 3'b010,
        CMD_ASSIGN = 3'b100,
        CMD_CLEAR  = 3'b110
    } cmd_t;
endpackage

// File: rtl/idcmd_ctrl_parse.sv
// Combinational split of a control byte into code match, command validity,
// output-enable bit and command. Assumes code in the top nibble, OE next,
// command in the low three bits.
module idcmd_ctrl_parse
    import idcmd_pkg::*;
#(
    parameter logic [3:0] CTRL_CODE = 4'b0110
) (
    input  logic [7:0] byte_i,
    output logic       code_ok_o,
    output logic       cmd_ok_o,
    output logic       oe_o,
    output cmd_t       cmd_o
);
    localparam int CODE_W = 4;
    localparam int OE_POS = 3;

    // Field extraction and command legality.
    always_comb begin
        code_ok_o = (byte_i[7 -: CODE_W] == CTRL_CODE);
        oe_o      = byte_i[OE_POS];
        cmd_o     = cmd_t'(byte_i[2:0]);
        case (byte_i[2:0])
            3'b000, 3'b001, 3'b010, 3'b100, 3'b110: cmd_ok_o = 1'b1;
            default:                                cmd_ok_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/idcmd_frame_track.sv
// Counts the bytes of a live frame and flags an early end. A frame opens on
// an accepted control byte and closes on START/STOP or on a drop request.
// Assumes open_i and drop_i are never raised together with end_i.
module idcmd_frame_track
    import idcmd_pkg::*;
#(
    parameter int SERIAL_BYTES    = 6,
    parameter int WRITE_MIN_BYTES = 4,
    parameter int CNT_W           = $clog2(SERIAL_BYTES + WRITE_MIN_BYTES + 4)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             end_i,
    input  logic             open_i,
    input  logic             byte_i,
    input  logic             drop_i,
    input  cmd_t             cmd_i,
    output logic             active_o,
    output logic [CNT_W-1:0] idx_o,
    output logic             abort_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] need;

    // Byte count each command needs before it counts as complete.
    always_comb begin
        case (cmd_i)
            CMD_WRITE, CMD_PROT: need = CNT_W'(WRITE_MIN_BYTES);
            CMD_ASSIGN:          need = CNT_W'(SERIAL_BYTES + 2);
            default:             need = CNT_W'(2);
        endcase
    end

    // Frame liveness, saturating byte count and abort pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            idx_o    <= '0;
            abort_o  <= 1'b0;
        end else begin
            abort_o <= end_i && active_o && (idx_o < need);
            if (end_i) begin
                active_o <= 1'b0;
                idx_o    <= '0;
            end else if (open_i) begin
                active_o <= 1'b1;
                idx_o    <= CNT_W'(1);
            end else if (drop_i) begin
                active_o <= 1'b0;
            end else if (byte_i && active_o && idx_o != CNT_MAX) begin
                idx_o <= idx_o + 1'b1;
            end
        end
    end

    // R11: a live frame always holds at least its control byte.
    p_live_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> (idx_o != '0));
endmodule

// File: rtl/idcmd_sel_latch.sv
// Latched select-pin request. It arms on an accepted identity byte, waits for
// that byte's acknowledge edge, and commits the OE value on the next SCL
// rising edge. START/STOP cancel a pending change.
module idcmd_sel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic cancel_i,
    input  logic arm_i,
    input  logic oe_i,
    input  logic ack_rise_i,
    input  logic scl_rise_i,
    output logic pull_o
);
    typedef enum logic [1:0] {S_IDLE, S_ACK, S_EDGE} st_t;

    st_t  st;
    logic pend;

    // Arm, wait for edges, commit the pending value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            pend   <= 1'b0;
            pull_o <= 1'b0;
        end else if (cancel_i) begin
            st <= S_IDLE;
        end else if (arm_i) begin
            st   <= S_ACK;
            pend <= oe_i;
        end else begin
            case (st)
                S_ACK:   if (ack_rise_i) st <= S_EDGE;
                S_EDGE:  if (scl_rise_i && !ack_rise_i) begin
                             pull_o <= pend;
                             st     <= S_IDLE;
                         end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R9: the pin only moves on an SCL rising edge.
    p_pull_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_rise_i |=> $stable(pull_o));
    // R12: a START/STOP never moves the pin.
    p_cancel_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_i |=> $stable(pull_o));
endmodule

// File: rtl/idcmd_decoder.sv
// Identity-filtered command decoder. It classifies the bytes after START
// (control, identity, rest), decides the acknowledge for each one, issues
// the command and drives the latched select-pin request. Assumes one-cycle
// strobes from a bit-level core, with byte_stb never in the same cycle as
// start_evt or stop_evt.
module idcmd_decoder
    import idcmd_pkg::*;
#(
    parameter logic [3:0] CTRL_CODE       = 4'b0110,
    parameter int         SERIAL_BYTES    = 6,
    parameter int         WRITE_MIN_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic       scl_rise,
    input  logic       ack_rise,
    input  logic       byte_stb,
    input  logic [7:0] rx_byte,
    input  logic [7:0] dev_id,
    input  logic       id_assigned,
    input  logic       wr_busy,
    output logic       ack_ok,
    output logic [2:0] cmd_sel,
    output logic       cmd_go,
    output logic       cmd_abort,
    output logic       sel_pull
);
    localparam int CNT_W = $clog2(SERIAL_BYTES + WRITE_MIN_BYTES + 4);

    logic             listen;
    logic             oe_q;
    cmd_t             cmd_q;
    logic             code_ok, cmd_ok, oe_new;
    cmd_t             cmd_new;
    logic             active;
    logic [CNT_W-1:0] idx;
    logic             frame_end;
    logic             ctrl_slot, id_slot, accept_ctrl, id_ok, id_accept;
    logic             wr_like, later_ok, drop, ack_next;

    idcmd_ctrl_parse #(.CTRL_CODE(CTRL_CODE)) u_parse (
        .byte_i    (rx_byte),
        .code_ok_o (code_ok),
        .cmd_ok_o  (cmd_ok),
        .oe_o      (oe_new),
        .cmd_o     (cmd_new)
    );

    // Byte classification and acknowledge decision.
    always_comb begin
        frame_end   = start_evt || stop_evt;
        ctrl_slot   = listen && !active;
        accept_ctrl = byte_stb && ctrl_slot && code_ok && cmd_ok && !wr_busy
                      && !(cmd_new == CMD_ASSIGN && id_assigned);
        id_slot     = active && (idx == CNT_W'(1));
        id_ok       = (cmd_q == CMD_CLEAR) || (cmd_q == CMD_ASSIGN)
                      || (rx_byte == dev_id);
        id_accept   = byte_stb && id_slot && !wr_busy && id_ok;
        wr_like     = (cmd_q == CMD_WRITE) || (cmd_q == CMD_PROT);
        later_ok    = wr_like && !wr_busy;
        drop        = (byte_stb && id_slot && !id_accept)
                      || (byte_stb && active && !id_slot && wr_like && wr_busy);
        ack_next    = accept_ctrl || id_accept
                      || (byte_stb && active && !id_slot && later_ok);
    end

    idcmd_frame_track #(
        .SERIAL_BYTES    (SERIAL_BYTES),
        .WRITE_MIN_BYTES (WRITE_MIN_BYTES),
        .CNT_W           (CNT_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .end_i    (frame_end),
        .open_i   (accept_ctrl),
        .byte_i   (byte_stb),
        .drop_i   (drop),
        .cmd_i    (cmd_q),
        .active_o (active),
        .idx_o    (idx),
        .abort_o  (cmd_abort)
    );

    idcmd_sel_latch u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .cancel_i   (frame_end),
        .arm_i      (id_accept),
        .oe_i       (oe_q),
        .ack_rise_i (ack_rise),
        .scl_rise_i (scl_rise),
        .pull_o     (sel_pull)
    );

    // Listen window, acknowledge hold, command latch and go pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            listen <= 1'b0;
            ack_ok <= 1'b0;
            cmd_go <= 1'b0;
            cmd_q  <= CMD_PROT;
            oe_q   <= 1'b0;
        end else if (frame_end) begin
            listen <= start_evt;
            ack_ok <= 1'b0;
            cmd_go <= 1'b0;
        end else begin
            cmd_go <= id_accept;
            if (byte_stb) ack_ok <= ack_next;
            if ((byte_stb && ctrl_slot && !accept_ctrl) || drop) listen <= 1'b0;
            if (accept_ctrl) begin
                cmd_q <= cmd_new;
                oe_q  <= oe_new;
            end
        end
    end

    assign cmd_sel = cmd_q;

    // R1: a wrong control code is never acknowledged.
    p_bad_code_nack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && ctrl_slot && rx_byte[7:4] != CTRL_CODE) |=> !ack_ok);
    // R3: an assigned device refuses the assign command.
    p_assigned_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && ctrl_slot && id_assigned && rx_byte[2:0] == 3'b100) |=> !ack_ok);
    // R4: an issued command is always backed by an acknowledge.
    p_go_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |-> ack_ok);
    // R7: no acknowledge during a write cycle.
    p_busy_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && wr_busy) |=> !ack_ok);
    // R11: abort follows only a START or STOP.
    p_abort_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_abort |-> $past(start_evt || stop_evt));
endmodule

// File: tb/idcmd_decoder_test.sv
module idcmd_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_evt = 1'b0, stop_evt = 1'b0, scl_rise = 1'b0, ack_rise = 1'b0;
    logic       byte_stb = 1'b0;
    logic [7:0] rx_byte = 8'h00, dev_id = 8'h00;
    logic       id_assigned = 1'b0, wr_busy = 1'b0;
    logic       ack_ok, cmd_go, cmd_abort, sel_pull;
    logic [2:0] cmd_sel;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    idcmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .scl_rise(scl_rise), .ack_rise(ack_rise), .byte_stb(byte_stb),
        .rx_byte(rx_byte), .dev_id(dev_id), .id_assigned(id_assigned),
        .wr_busy(wr_busy), .ack_ok(ack_ok), .cmd_sel(cmd_sel), .cmd_go(cmd_go),
        .cmd_abort(cmd_abort), .sel_pull(sel_pull)
    );

    always #2 clk = ~clk;

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b, input logic ea, input logic eg, input string tag);
        @(negedge clk); byte_stb = 1'b1; rx_byte = b;
        @(negedge clk); byte_stb = 1'b0;
        chk(8'(ack_ok), 8'(ea), {tag, " ack"});
        chk(8'(cmd_go), 8'(eg), {tag, " go"});
    endtask

    task automatic ack_clk;
        @(negedge clk); ack_rise = 1'b1; scl_rise = 1'b1;
        @(negedge clk); ack_rise = 1'b0; scl_rise = 1'b0;
    endtask

    task automatic bit_clk;
        @(negedge clk); scl_rise = 1'b1;
        @(negedge clk); scl_rise = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] b, input logic ea, input logic eg, input string tag);
        put_byte(b, ea, eg, tag);
        ack_clk();
        bit_clk();
    endtask

    task automatic do_start;
        @(negedge clk); start_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0;
    endtask

    task automatic end_frame(input bit by_start, input logic ex_abort, input string tag);
        @(negedge clk); if (by_start) start_evt = 1'b1; else stop_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0; stop_evt = 1'b0;
        chk(8'(cmd_abort), 8'(ex_abort), {tag, " abort"});
    endtask

    task automatic t_reset;
        chk(8'(sel_pull), 8'd0, "R8 sel_pull");
        chk(8'(ack_ok), 8'd0, "R8 ack_ok");
        chk(8'(cmd_go), 8'd0, "R8 cmd_go");
        chk(8'(cmd_abort), 8'd0, "R8 cmd_abort");
        chk(8'(cmd_sel), 8'd0, "R8 cmd_sel");
    endtask

    task automatic t_write_default;
        do_start();
        xfer(8'h6A, 1, 0, "R2 write ctrl");
        chk(8'(cmd_sel), 8'd2, "R2 write code");
        put_byte(8'h00, 1, 1, "R4 write id match");
        ack_clk();
        chk(8'(sel_pull), 8'd0, "R9 not before edge");
        bit_clk();
        chk(8'(sel_pull), 8'd1, "R9 commit oe=1");
        xfer(8'h10, 1, 0, "R5 write addr");
        xfer(8'h55, 1, 0, "R5 write data");
        end_frame(0, 0, "R11 full write");
    endtask

    task automatic t_id_mismatch;
        do_start();
        xfer(8'h62, 1, 0, "R4 ctrl");
        xfer(8'h05, 0, 0, "R4 id mismatch");
        chk(8'(sel_pull), 8'd1, "R10 hold on mismatch");
        put_byte(8'h00, 0, 0, "R4 after mismatch");
        end_frame(0, 0, "R11 dropped frame");
    endtask

    task automatic t_read;
        do_start();
        xfer(8'h61, 1, 0, "R2 read ctrl");
        chk(8'(cmd_sel), 8'd1, "R2 read code");
        xfer(8'h00, 1, 1, "R4 read id");
        chk(8'(sel_pull), 8'd0, "R9 commit oe=0");
        xfer(8'hC3, 0, 0, "R5 read data");
        end_frame(0, 0, "R11 read done");
    endtask

    task automatic t_bad_ctrl;
        do_start();
        xfer(8'hAA, 0, 0, "R1 bad code");
        xfer(8'h00, 0, 0, "R1 ignored id");
        chk(8'(sel_pull), 8'd0, "R1 pin untouched");
        end_frame(0, 0, "R1 no abort");
        do_start();
        xfer(8'h6B, 0, 0, "R1 bad cmd bits");
        xfer(8'h00, 0, 0, "R1 ignored id2");
        chk(8'(sel_pull), 8'd0, "R10 pin held");
        end_frame(0, 0, "R1 no abort2");
    endtask

    task automatic t_short_write;
        do_start();
        xfer(8'h62, 1, 0, "R11 ctrl");
        xfer(8'h00, 1, 1, "R11 id");
        xfer(8'h20, 1, 0, "R11 addr");
        end_frame(0, 1, "R11 short write");
        @(negedge clk);
        chk(8'(cmd_abort), 8'd0, "R11 abort one cycle");
    endtask

    task automatic t_busy;
        wr_busy = 1'b1;
        do_start();
        xfer(8'h6A, 0, 0, "R7 busy ctrl");
        end_frame(0, 0, "R7 no abort");
        wr_busy = 1'b0;
        do_start();
        xfer(8'h6A, 1, 0, "R7 ctrl");
        xfer(8'h00, 1, 1, "R7 id");
        chk(8'(sel_pull), 8'd1, "R9 oe=1 again");
        wr_busy = 1'b1;
        xfer(8'h30, 0, 0, "R7 busy addr");
        wr_busy = 1'b0;
        xfer(8'h31, 0, 0, "R7 dropped data");
        end_frame(0, 0, "R7 dropped no abort");
    endtask

    task automatic t_assign;
        do_start();
        xfer(8'h64, 1, 0, "R2 assign ctrl");
        chk(8'(cmd_sel), 8'd4, "R2 assign code");
        xfer(8'h37, 1, 1, "R6 assign id");
        chk(8'(sel_pull), 8'd0, "R9 assign oe=0");
        for (int i = 0; i < 6; i++) xfer(8'h5A, 0, 0, "R5 serial");
        end_frame(0, 0, "R11 full assign");
        do_start();
        xfer(8'h6C, 1, 0, "R6 ctrl2");
        xfer(8'h37, 1, 1, "R6 id2");
        chk(8'(sel_pull), 8'd1, "R9 assign oe=1");
        xfer(8'h11, 0, 0, "R5 serial2");
        xfer(8'h22, 0, 0, "R5 serial3");
        end_frame(0, 1, "R11 short assign");
        id_assigned = 1'b1; dev_id = 8'h37;
        do_start();
        xfer(8'h64, 0, 0, "R3 assigned refuses");
        chk(8'(sel_pull), 8'd1, "R10 hold after refuse");
        end_frame(0, 0, "R3 no abort");
    endtask

    task automatic t_assigned_read;
        do_start();
        xfer(8'h61, 1, 0, "R4 ctrl");
        xfer(8'h37, 1, 1, "R4 id 37 match");
        chk(8'(sel_pull), 8'd0, "R9 read release");
        end_frame(0, 0, "R11 read ok");
        do_start();
        xfer(8'h69, 1, 0, "R4 ctrl2");
        xfer(8'h00, 0, 0, "R4 id 00 mismatch");
        chk(8'(sel_pull), 8'd0, "R10 hold");
        end_frame(0, 0, "R4 no abort");
    endtask

    task automatic t_clear;
        do_start();
        xfer(8'h6E, 1, 0, "R2 clear ctrl");
        chk(8'(cmd_sel), 8'd6, "R2 clear code");
        xfer(8'hFF, 1, 1, "R6 clear any id");
        chk(8'(sel_pull), 8'd1, "R9 clear oe=1");
        end_frame(0, 0, "R11 clear done");
    endtask

    task automatic t_cancel;
        do_start();
        xfer(8'h62, 1, 0, "R12 ctrl");
        put_byte(8'h37, 1, 1, "R12 id");
        ack_clk();
        end_frame(1, 1, "R12 restart abort");
        bit_clk();
        chk(8'(sel_pull), 8'd1, "R12 pending cancelled");
        end_frame(0, 0, "R12 idle stop");
    endtask

    task automatic t_protect;
        do_start();
        xfer(8'h60, 1, 0, "R2 protect ctrl");
        chk(8'(cmd_sel), 8'd0, "R2 protect code");
        xfer(8'h37, 1, 1, "R4 protect id");
        chk(8'(sel_pull), 8'd0, "R9 protect oe=0");
        xfer(8'h80, 1, 0, "R5 protect addr");
        xfer(8'h00, 1, 0, "R5 protect data");
        end_frame(0, 0, "R11 protect done");
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_default();
        t_id_mismatch();
        t_read();
        t_bad_ctrl();
        t_short_write();
        t_busy();
        t_assign();
        t_assigned_read();
        t_clear();
        t_cancel();
        t_protect();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule